// File: doc/BRIEF.md
# Dual-Bank Selectable Clock Divider

This block sits behind a synthesizer's VCO and turns one fast source clock into two banks of divided clocks. Each bank, A and B, has its own 2-bit ratio code, its own drive enable and two identical clock outputs, each with a complement. The two banks decode their codes independently. They share the source clock, the master reset and the reference routing.

The source clock is normally the VCO clock. When the active-low bypass input is asserted, one of two reference clocks feeds the dividers in its place. A reference-select input picks which one. Every ratio, the odd one included, gives a 50% duty cycle. The odd ratio uses a half-period extension clocked on the falling edge. A ratio change is resynchronised and applied only when a divided period ends. A master reset clears the dividers. When it is released, all four outputs start their first high phase together.

Top module: `dual_bank_clkdiv`

## Requirements
- R1: Each bank divides the source clock by a ratio set by its own 2-bit code: 2'b00 selects 25, 2'b01 selects 8, 2'b10 selects 16 and 2'b11 selects 20. The output period is that many source periods, and one bank's code never affects the other bank.
- R2: Every output is high for exactly half its period. For ratio 25 this is 12.5 source periods, so the block uses both source clock edges.
- R3: Both outputs of a bank carry the same divided clock, and each complement output is always the inverse of its true output.
- R4: While the master reset is high, every true output is low and every complement is high. This takes effect without waiting for a clock edge.
- R5: After the master reset falls, the source clock rises twice while the release is synchronised. On the third rising edge, all four true outputs go high together and begin their first period.
- R6: When a bank's output-enable input is low, that bank's drive-enable output is low at once, so the pad drivers go high-impedance. The other bank's drive enable is unchanged. The disabled bank's divider keeps its ratio and period.
- R7: With the active-low bypass input low, the dividers count the selected reference clock instead of the VCO clock. The output period becomes the ratio times the reference period.
- R8: The reference select value 0 picks the primary reference and 1 picks the alternate reference. It has no effect while the bypass input is high.
- R9: A code change is applied only at the end of a divided period. During the switch, every high or low interval equals the half period of either the old or the new ratio, so no runt pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Fast multiplied source clock |
| ref_pri_clk | input | 1 | Primary reference clock |
| ref_alt_clk | input | 1 | Alternate reference clock |
| ref_alt_sel | input | 1 | 1 selects the alternate reference, 0 the primary |
| pll_bypass_n | input | 1 | Low routes the selected reference to the dividers |
| mreset | input | 1 | Asynchronous master reset, active high |
| sel_a | input | 2 | Bank A ratio code |
| sel_b | input | 2 | Bank B ratio code |
| oe_a | input | 1 | Bank A output enable |
| oe_b | input | 1 | Bank B output enable |
| a_clk | output | OUTS_PER_BANK | Bank A true clocks |
| a_clk_n | output | OUTS_PER_BANK | Bank A complement clocks |
| a_drv_en | output | 1 | Bank A pad drive enable |
| b_clk | output | OUTS_PER_BANK | Bank B true clocks |
| b_clk_n | output | OUTS_PER_BANK | Bank B complement clocks |
| b_drv_en | output | 1 | Bank B pad drive enable |

## Verification
The bench builds the block with its default parameters: ratios 25, 8, 16 and 20, two outputs per bank and a two-stage reset synchroniser. This puts one odd ratio and three even ratios in reach. Those ratios cover the falling-edge half-period path and the plain even path, plus every transition between the two. Two output copies per bank are enough to check that the copies match. The 5-bit counter is exercised up to its largest value, 24.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

  typedef logic [1:0] fsel_t;

  function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/clk_src_select.sv
`timescale 1ns/1ps
module clk_src_select (
  input  logic vco_clk_i,
  input  logic ref_pri_i,
  input  logic ref_alt_i,
  input  logic alt_sel_i,
  input  logic bypass_ni,
  output logic src_clk_o
);

  logic ref_clk;

  always_comb begin
    ref_clk   = alt_sel_i ? ref_alt_i : ref_pri_i;
    src_clk_o = bypass_ni ? vco_clk_i : ref_clk;
  end

endmodule

// File: rtl/rst_sync.sv
`timescale 1ns/1ps
module rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nx;

  always_comb begin
    chain_nx = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= chain_nx;
  end

  assign rst_no = chain_q[STAGES-1];

  // R5: release only after the async input has been high at a prior edge
  a_r5_release_synchronous: assert property (@(posedge clk_i) disable iff (!arst_ni)
    $rose(rst_no) |-> $past(arst_ni));

endmodule

// File: rtl/clkdiv_bank.sv
`timescale 1ns/1ps
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int unsigned RATIO0 = 25,
  parameter int unsigned RATIO1 = 8,
  parameter int unsigned RATIO2 = 16,
  parameter int unsigned RATIO3 = 20
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  fsel_t sel_i,
  output logic  div_o
);

  localparam int unsigned RMAX = max_of4(RATIO0, RATIO1, RATIO2, RATIO3);
  localparam int unsigned RW   = $clog2(RMAX + 1);

  typedef logic [RW-1:0] ratio_t;

  fsel_t  sel_m_q, sel_s_q;
  ratio_t sel_ratio;
  ratio_t n_q, n_nx;
  ratio_t cnt_q, cnt_nx;
  ratio_t half;
  logic   armed_q;
  logic   odd_q, odd_nx;
  logic   ph_r_q, ph_r_nx;
  logic   ph_f_q;
  logic   wrap;

  // code synchroniser (data path only, no reset needed)
  always_ff @(posedge clk_i) begin
    sel_m_q <= sel_i;
    sel_s_q <= sel_m_q;
  end

  always_comb begin
    case (sel_s_q)
      2'd0:    sel_ratio = ratio_t'(RATIO0);
      2'd1:    sel_ratio = ratio_t'(RATIO1);
      2'd2:    sel_ratio = ratio_t'(RATIO2);
      default: sel_ratio = ratio_t'(RATIO3);
    endcase
  end

  assign half = n_q >> 1;
  assign wrap = !armed_q || (cnt_q == n_q - ratio_t'(1));

  always_comb begin
    n_nx    = n_q;
    odd_nx  = odd_q;
    cnt_nx  = cnt_q + ratio_t'(1);
    ph_r_nx = (cnt_nx < half);
    if (wrap) begin
      n_nx    = sel_ratio;
      odd_nx  = sel_ratio[0];
      cnt_nx  = '0;
      ph_r_nx = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      n_q     <= ratio_t'(RATIO0);
      odd_q   <= 1'b0;
      cnt_q   <= '0;
      ph_r_q  <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      n_q     <= n_nx;
      odd_q   <= odd_nx;
      cnt_q   <= cnt_nx;
      ph_r_q  <= ph_r_nx;
    end
  end

  // half-period extension for odd ratios
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_f_q <= 1'b0;
    else         ph_f_q <= ph_r_q;
  end

  assign div_o = ph_r_q | (odd_q & ph_f_q);

  // R1: counter stays inside the active ratio
  a_r1_count_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (cnt_q < n_q));

  // R9: the ratio changes only at the end of a divided period
  a_r9_ratio_swap_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(armed_q) && !$stable(n_q)) |-> ($past(cnt_q) == $past(n_q) - ratio_t'(1)));

  // R2: each high phase starts at count zero
  a_r2_high_starts_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ph_r_q) |-> (cnt_q == '0));

endmodule

// File: rtl/dual_bank_clkdiv.sv
`timescale 1ns/1ps
module dual_bank_clkdiv
  import clkdiv_pkg::*;
#(
  parameter int unsigned OUTS_PER_BANK = 2,
  parameter int unsigned RATIO0        = 25,
  parameter int unsigned RATIO1        = 8,
  parameter int unsigned RATIO2        = 16,
  parameter int unsigned RATIO3        = 20,
  parameter int unsigned RST_STAGES    = 2
) (
  input  logic                     vco_clk,
  input  logic                     ref_pri_clk,
  input  logic                     ref_alt_clk,
  input  logic                     ref_alt_sel,
  input  logic                     pll_bypass_n,
  input  logic                     mreset,
  input  logic [1:0]               sel_a,
  input  logic [1:0]               sel_b,
  input  logic                     oe_a,
  input  logic                     oe_b,
  output logic [OUTS_PER_BANK-1:0] a_clk,
  output logic [OUTS_PER_BANK-1:0] a_clk_n,
  output logic                     a_drv_en,
  output logic [OUTS_PER_BANK-1:0] b_clk,
  output logic [OUTS_PER_BANK-1:0] b_clk_n,
  output logic                     b_drv_en
);

  localparam int unsigned NBANKS = 2;

  logic              src_clk;
  logic              mreset_n;
  logic              core_rst_n;
  fsel_t             bank_sel [NBANKS];
  logic [NBANKS-1:0] bank_div;

  assign mreset_n    = ~mreset;
  assign bank_sel[0] = sel_a;
  assign bank_sel[1] = sel_b;

  clk_src_select u_src (
    .vco_clk_i (vco_clk),
    .ref_pri_i (ref_pri_clk),
    .ref_alt_i (ref_alt_clk),
    .alt_sel_i (ref_alt_sel),
    .bypass_ni (pll_bypass_n),
    .src_clk_o (src_clk)
  );

  rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i   (src_clk),
    .arst_ni (mreset_n),
    .rst_no  (core_rst_n)
  );

  for (genvar g = 0; g < NBANKS; g++) begin : g_bank
    clkdiv_bank #(
      .RATIO0 (RATIO0),
      .RATIO1 (RATIO1),
      .RATIO2 (RATIO2),
      .RATIO3 (RATIO3)
    ) u_div (
      .clk_i  (src_clk),
      .rst_ni (core_rst_n),
      .sel_i  (bank_sel[g]),
      .div_o  (bank_div[g])
    );
  end

  for (genvar k = 0; k < OUTS_PER_BANK; k++) begin : g_fanout
    assign a_clk[k]   = bank_div[0];
    assign a_clk_n[k] = ~bank_div[0];
    assign b_clk[k]   = bank_div[1];
    assign b_clk_n[k] = ~bank_div[1];
  end

  assign a_drv_en = oe_a;
  assign b_drv_en = oe_b;

  // R4: no divided clock is high while master reset is held
  a_r4_reset_forces_low: assert property (@(posedge src_clk)
    mreset |-> (bank_div == '0));

endmodule

// File: tb/tb_dual_bank_clkdiv.sv
`timescale 1ns/1ps
module tb_dual_bank_clkdiv;

  localparam real TV = 5.0;
  localparam real TP = 16.0;
  localparam real TA = 12.0;

  logic       vco_clk = 1'b0;
  logic       ref_pri_clk = 1'b0;
  logic       ref_alt_clk = 1'b0;
  logic       ref_alt_sel;
  logic       pll_bypass_n;
  logic       mreset;
  logic [1:0] sel_a, sel_b;
  logic       oe_a, oe_b;
  logic [1:0] a_clk, a_clk_n, b_clk, b_clk_n;
  logic       a_drv_en, b_drv_en;

  int n_checks = 0;
  int n_fail   = 0;

  dual_bank_clkdiv dut (
    .vco_clk(vco_clk), .ref_pri_clk(ref_pri_clk), .ref_alt_clk(ref_alt_clk),
    .ref_alt_sel(ref_alt_sel), .pll_bypass_n(pll_bypass_n), .mreset(mreset),
    .sel_a(sel_a), .sel_b(sel_b), .oe_a(oe_a), .oe_b(oe_b),
    .a_clk(a_clk), .a_clk_n(a_clk_n), .a_drv_en(a_drv_en),
    .b_clk(b_clk), .b_clk_n(b_clk_n), .b_drv_en(b_drv_en)
  );

  wire [1:0] mon = {b_clk[0], a_clk[0]};

  initial forever #2.5 vco_clk = ~vco_clk;
  initial forever #8.0 ref_pri_clk = ~ref_pri_clk;
  initial forever #6.0 ref_alt_clk = ~ref_alt_clk;

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #1000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    finish_run();
  end

  function automatic int ratio_of(input logic [1:0] s);
    case (s)
      2'd0: return 25;
      2'd1: return 8;
      2'd2: return 16;
      default: return 20;
    endcase
  endfunction

  function automatic bit near(input real a, input real b);
    return (a < b + 0.01) && (a > b - 0.01);
  endfunction

  task automatic check_real(input string req, input string what, input real act, input real exp);
    n_checks++;
    if (!near(act, exp)) begin
      n_fail++;
      $display("FAIL %s %s actual=%0.3f expected=%0.3f", req, what, act, exp);
    end
  endtask

  task automatic check_bits(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // measure period and high time of one bank (R1, R2) and check copies (R3)
  task automatic measure(input int bk, input real tsrc, input logic [1:0] s, input string req);
    real t0, t1, t2;
    int  n;
    n = ratio_of(s);
    repeat (2) begin
      wait (mon[bk] == 1'b0);
      wait (mon[bk] == 1'b1);
    end
    t0 = $realtime;
    #1;
    if (bk == 0) begin
      check_bits("R3", "bank A copies", {6'd0, a_clk}, 8'h03);
      check_bits("R3", "bank A complements", {6'd0, a_clk_n}, 8'h00);
    end else begin
      check_bits("R3", "bank B copies", {6'd0, b_clk}, 8'h03);
      check_bits("R3", "bank B complements", {6'd0, b_clk_n}, 8'h00);
    end
    wait (mon[bk] == 1'b0);
    t1 = $realtime;
    wait (mon[bk] == 1'b1);
    t2 = $realtime;
    check_real(req, $sformatf("bank %0d period code %0d", bk, s), t2 - t0, n * tsrc);
    check_real("R2", $sformatf("bank %0d high time code %0d", bk, s), t1 - t0, n * tsrc / 2.0);
    #1.3;
  endtask

  // R9: switch code at an arbitrary instant and check every interval
  task automatic switch_check(input int bk, input logic [1:0] from_s, input logic [1:0] to_s);
    real hf, ht, tprev, tnow;
    logic lvl;
    hf = ratio_of(from_s) * TV / 2.0;
    ht = ratio_of(to_s) * TV / 2.0;
    if (bk == 0) sel_a = from_s; else sel_b = from_s;
    measure(bk, TV, from_s, "R1");
    #(real'($urandom % 60) + 1.3);
    if (bk == 0) sel_a = to_s; else sel_b = to_s;
    lvl = mon[bk];
    wait (mon[bk] != lvl);
    tprev = $realtime;
    for (int i = 0; i < 12; i++) begin
      lvl = mon[bk];
      wait (mon[bk] != lvl);
      tnow = $realtime;
      n_checks++;
      if (!near(tnow - tprev, hf) && !near(tnow - tprev, ht)) begin
        n_fail++;
        $display("FAIL R9 interval bank %0d actual=%0.3f expected=%0.3f or %0.3f",
                 bk, tnow - tprev, hf, ht);
      end
      tprev = tnow;
    end
    measure(bk, TV, to_s, "R9");
  endtask

  // R5: release reset 1.5 ns after a rising edge, expect all rises at the third edge
  task automatic release_aligned();
    real ta, tb, trel;
    @(posedge vco_clk);
    #1.5;
    mreset = 1'b0;
    trel = $realtime;
    fork
      begin wait (a_clk[0] == 1'b1); ta = $realtime; end
      begin wait (b_clk[0] == 1'b1); tb = $realtime; end
    join
    check_real("R5", "bank A first rise", ta, trel + 13.5);
    check_real("R5", "bank B first rise", tb, trel + 13.5);
    #1;
    check_bits("R5", "all outputs high together", {4'd0, b_clk, a_clk}, 8'h0f);
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd7741);
    mreset = 1'b1; sel_a = 2'b00; sel_b = 2'b10; oe_a = 1'b1; oe_b = 1'b1;
    pll_bypass_n = 1'b1; ref_alt_sel = 1'b0;
    #20.3;
    // R4 reset state
    check_bits("R4", "true outputs in reset", {4'd0, b_clk, a_clk}, 8'h00);
    check_bits("R4", "complements in reset", {4'd0, b_clk_n, a_clk_n}, 8'h0f);
    check_bits("R6", "drive enables with oe high", {6'd0, b_drv_en, a_drv_en}, 8'h03);

    release_aligned();
    measure(0, TV, 2'b00, "R1");
    measure(1, TV, 2'b10, "R1");

    // directed: every code on both banks, banks differing (R1)
    for (int s = 0; s < 4; s++) begin
      sel_a = 2'(s);
      sel_b = 2'(3 - s);
      measure(0, TV, 2'(s), "R1");
      measure(1, TV, 2'(3 - s), "R1");
    end

    // constrained random codes (R1, R2)
    for (int i = 0; i < 6; i++) begin
      sel_a = 2'($urandom % 4);
      sel_b = 2'($urandom % 4);
      measure(0, TV, sel_a, "R1");
      measure(1, TV, sel_b, "R1");
    end

    // code switching without runts (R9)
    switch_check(0, 2'b01, 2'b00);
    switch_check(1, 2'b10, 2'b11);
    switch_check(0, 2'b00, 2'b01);

    // output enable (R6)
    sel_a = 2'b11; sel_b = 2'b01;
    #1.3;
    oe_a = 1'b0;
    #1;
    check_bits("R6", "bank A disabled, B enabled", {6'd0, b_drv_en, a_drv_en}, 8'h02);
    measure(0, TV, 2'b11, "R6");
    oe_a = 1'b1; oe_b = 1'b0;
    #1;
    check_bits("R6", "bank B disabled, A enabled", {6'd0, b_drv_en, a_drv_en}, 8'h01);
    measure(1, TV, 2'b01, "R6");
    oe_b = 1'b1;

    // mid-run reset (R4, R5)
    sel_a = 2'b00; sel_b = 2'b00;
    wait (a_clk[0] == 1'b1);
    #3.3;
    mreset = 1'b1;
    #0.5;
    check_bits("R4", "true outputs low at once", {4'd0, b_clk, a_clk}, 8'h00);
    check_bits("R4", "complements high at once", {4'd0, b_clk_n, a_clk_n}, 8'h0f);
    #97;
    check_bits("R4", "outputs held low", {4'd0, b_clk, a_clk}, 8'h00);
    release_aligned();

    // bypass and reference select (R7, R8)
    sel_a = 2'b01; sel_b = 2'b11;
    #1.3;
    pll_bypass_n = 1'b0; ref_alt_sel = 1'b0;
    measure(0, TP, 2'b01, "R7");
    measure(1, TP, 2'b11, "R7");
    ref_alt_sel = 1'b1;
    measure(0, TA, 2'b01, "R8");
    sel_a = 2'b00;
    measure(0, TA, 2'b00, "R8");
    measure(1, TA, 2'b11, "R8");
    pll_bypass_n = 1'b1;
    measure(0, TV, 2'b00, "R8");
    ref_alt_sel = 1'b0;
    measure(0, TV, 2'b00, "R8");

    finish_run();
  end

endmodule